// File: doc/BRIEF.md
# Grayscale Page Pixel Packer

This block turns a window of an 8-bit-per-pixel grayscale frame buffer into the byte stream that a display controller with 4-bit pixel memory expects. The display memory stores two pixels in every byte and groups lines into pages that are two lines tall. When a transfer starts, the block first sends four address commands that place the display's write pointer at the window origin. It then reads the frame buffer through a synchronous read port, packs the upper nibbles of pixel pairs into bytes and offers them on a valid/ready output.

Two orientations are supported. In the normal orientation a byte holds two vertically adjacent pixels and the first line is rounded down to an even line. In the rotated orientation a byte holds two horizontally adjacent pixels, and the address commands take their coordinates in swapped roles. The output link is either 8 bits wide, with a separate data/command line, or 9 bits wide, with bit 8 marking data words. Any other bus width is refused.

The window always covers whole lines from the start line to the end line. The end line must not be smaller than the start line and must lie inside the frame.

Top module: `gray_page_packer`

## Requirements
- R1: Every data byte carries the upper nibble of its first pixel in bits 3:0 and the upper nibble of its second pixel in bits 7:4.
- R2: In normal orientation (rotated = 0) the second pixel of a byte is the same column on the following line. Processing starts at the start line with bit 0 cleared and covers line pairs up to the end line, with FB_W bytes per pair in column order 0 to FB_W-1.
- R3: In normal orientation each byte reads the first pixel at address A and then the second at A+FB_W. A grows by one per byte and jumps by one extra line after each line pair, where a pixel at (column c, line y) lives at address y*FB_W+c.
- R4: In rotated orientation (rotated = 1) each line from the start line to the end line gives FB_W/2 bytes. Each byte reads address A and then A+1, and A grows by two per byte.
- R5: In normal orientation exactly four command words precede the data, in this order: 0x00|win_x[3:0], 0x10|win_x[7:4], 0x60|(win_y0>>1)[3:0], 0x70|win_y0[7:5].
- R6: In rotated orientation the same four commands are built from win_y0 in place of win_x, and from win_x in place of win_y0.
- R7: With bus_bits = 9, every data word is 0x100 OR'd with the packed byte, every command word has bit 8 clear, and out_dc stays low.
- R8: With bus_bits = 8, out_word[8] is always 0, and out_dc is low for command words and high for every data word.
- R9: A start with bus_bits other than 8 or 9 produces no output word and no frame-buffer read. err rises in the following cycle and holds until the next start with a supported bus width, which clears it.
- R10: While out_valid is high and out_ready is low, out_word, out_dc and out_last hold steady and out_valid stays high.
- R11: out_last is high on the final data word of the window and on no other word.
- R12: fb_rd_data is taken one cycle after fb_rd_en. No read is issued while a word is offered, and every read address is below FB_W*FB_H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a window transfer; taken only while idle |
| rotated | input | 1 | 0 = normal orientation, 1 = rotated orientation |
| bus_bits | input | 4 | Output link width: 8 or 9; other values are refused |
| win_x | input | 8 | Window origin column used in the address commands |
| win_y0 | input | 8 | First line of the window |
| win_y1 | input | 8 | Last line of the window |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last start carried an unsupported bus width |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_rd_addr | output | AW | Frame-buffer pixel address |
| fb_rd_data | input | 8 | Frame-buffer pixel, one cycle after the strobe |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output word accepted |
| out_word | output | 9 | Command or data word |
| out_dc | output | 1 | Data/command line for the 8-bit link |
| out_last | output | 1 | Final data word of the window |

## Verification
The embedded assertions check on every cycle that a stalled word holds, that err keeps the block silent, that a data flag and the data line never appear together, that the last flag only rides on data words, and that reads stay inside the frame and never overlap an offered word. They also check that the address walker's pointer always agrees with its line and column counters, and that the second pixel is captured right after the first. The packed byte values, the read address order in both orientations, the even-line rounding, the command contents with their swapped coordinates, and the position of the last flag are only shown by the bench scenarios. These scenarios compare every word and every read against a scoreboard under random back-pressure.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = BYTE_W + 1;
    localparam int COORD_W = 8;

    // display command opcodes (upper nibble of the command byte)
    localparam logic [7:0] OP_COL_LO  = 8'h00;
    localparam logic [7:0] OP_COL_HI  = 8'h10;
    localparam logic [7:0] OP_PAGE_LO = 8'h60;
    localparam logic [7:0] OP_PAGE_HI = 8'h70;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD_A,
        ST_RD_B,
        ST_CAP,
        ST_DATA
    } state_e;

    typedef enum logic {
        LINK_8 = 1'b0,
        LINK_9 = 1'b1
    } link_e;

    typedef struct packed {
        logic               rot;
        link_e              link;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y0;
    } win_t;

    function automatic logic bus_supported(input logic [3:0] bits);
        return (bits == 4'd8) || (bits == 4'd9);
    endfunction

    // first pixel -> low nibble, second pixel -> high nibble
    function automatic logic [BYTE_W-1:0] pack_pair(input logic [BYTE_W-1:0] first,
                                                    input logic [BYTE_W-1:0] second);
        return {second[BYTE_W-1 -: 4], first[BYTE_W-1 -: 4]};
    endfunction

    // idx 0..3: column low, column high, page low, page high
    function automatic logic [7:0] cmd_byte(input logic [1:0]         idx,
                                            input logic [COORD_W-1:0] col,
                                            input logic [COORD_W-1:0] line);
        logic [7:0] b;
        case (idx)
            2'd0:    b = OP_COL_LO  | {4'h0, col[3:0]};
            2'd1:    b = OP_COL_HI  | {4'h0, col[7:4]};
            2'd2:    b = OP_PAGE_LO | {4'h0, line[4:1]};
            default: b = OP_PAGE_HI | {5'h00, line[7:5]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpp_walker.sv
module gpp_walker
    import gpp_pkg::*;
#(
    parameter int FB_W = 240,
    parameter int AW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               rot_in,
    input  logic [COORD_W-1:0] y0_in,
    input  logic [COORD_W-1:0] y1_in,
    input  logic               step,
    output logic [AW-1:0]      addr_a,
    output logic [AW-1:0]      addr_b,
    output logic               last_unit
);

    localparam logic [COORD_W-1:0] COL_END_N = COORD_W'(FB_W - 1);
    localparam logic [COORD_W-1:0] COL_END_R = COORD_W'(FB_W / 2 - 1);
    localparam logic [COORD_W:0]   PAIR_SPAN = (COORD_W + 1)'(2);
    localparam logic [AW-1:0]      LINE_JUMP = AW'(FB_W + 1);
    localparam logic [AW-1:0]      LINE_LEN  = AW'(FB_W);

    logic [AW-1:0]      addr_q;
    logic [COORD_W-1:0] col_q;
    logic [COORD_W-1:0] row_q;
    logic [COORD_W-1:0] y1_q;
    logic               rot_q;
    logic               armed_q;
    logic               line_end;
    logic [COORD_W-1:0] row_start;

    assign line_end  = (col_q == (rot_q ? COL_END_R : COL_END_N));
    assign row_start = rot_in ? y0_in : {y0_in[COORD_W-1:1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
            y1_q    <= '0;
            rot_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (load) begin
            addr_q  <= AW'(row_start) * LINE_LEN;
            col_q   <= '0;
            row_q   <= row_start;
            y1_q    <= y1_in;
            rot_q   <= rot_in;
            armed_q <= 1'b1;
        end else if (step) begin
            col_q <= line_end ? '0 : col_q + 1'b1;
            if (rot_q) begin
                addr_q <= addr_q + AW'(2);
                row_q  <= line_end ? row_q + 1'b1 : row_q;
            end else begin
                addr_q <= addr_q + (line_end ? LINE_JUMP : AW'(1));
                row_q  <= line_end ? row_q + COORD_W'(2) : row_q;
            end
        end
    end

    assign addr_a = addr_q;
    assign addr_b = addr_q + (rot_q ? AW'(1) : LINE_LEN);

    always_comb begin
        if (rot_q) last_unit = line_end && (row_q >= y1_q);
        else       last_unit = line_end && (({1'b0, row_q} + PAIR_SPAN) > {1'b0, y1_q});
    end

    // pointer must always sit at row*width + column offset (R3 normal, R4 rotated)
    assert_addr_tracks_row_R3: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> addr_q == AW'(row_q) * LINE_LEN
                              + (rot_q ? AW'({col_q, 1'b0}) : AW'(col_q)));

    // normal orientation only ever walks even rows
    assert_even_page_row_R2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !rot_q) |-> !row_q[0]);

endmodule

// File: rtl/gpp_pair.sv
module gpp_pair
    import gpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_first,
    input  logic              cap_second,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] byte_out
);

    logic [BYTE_W-1:0] first_q;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            byte_q  <= '0;
        end else begin
            if (cap_first)  first_q <= rd_data;
            if (cap_second) byte_q  <= pack_pair(first_q, rd_data);
        end
    end

    assign byte_out = byte_q;

    // second pixel is captured exactly one cycle after the first
    assert_second_after_first_R1: assert property (@(posedge clk) disable iff (rst)
        cap_second |-> $past(cap_first));

    assert_capture_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        cap_first |-> !cap_second);

endmodule

// File: rtl/gray_page_packer.sv
module gray_page_packer
    import gpp_pkg::*;
#(
    parameter int FB_W = 240,
    parameter int FB_H = 160,
    localparam int AW  = $clog2(FB_W * FB_H)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               rotated,
    input  logic [3:0]         bus_bits,
    input  logic [COORD_W-1:0] win_x,
    input  logic [COORD_W-1:0] win_y0,
    input  logic [COORD_W-1:0] win_y1,
    output logic               busy,
    output logic               err,
    output logic               fb_rd_en,
    output logic [AW-1:0]      fb_rd_addr,
    input  logic [BYTE_W-1:0]  fb_rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_word,
    output logic               out_dc,
    output logic               out_last
);

    localparam logic [AW-1:0] FRAME_PIX = AW'(FB_W * FB_H);

    state_e             state_q;
    state_e             state_d;
    win_t               win_q;
    logic [1:0]         cmd_idx_q;
    logic               err_q;
    logic               walk_load;
    logic               walk_step;
    logic               last_unit;
    logic [AW-1:0]      addr_a;
    logic [AW-1:0]      addr_b;
    logic [BYTE_W-1:0]  packed_byte;
    logic [COORD_W-1:0] col_v;
    logic [COORD_W-1:0] line_v;
    logic               accept;

    assign accept    = out_valid && out_ready;
    assign walk_load = (state_q == ST_IDLE) && start && bus_supported(bus_bits);
    assign walk_step = (state_q == ST_DATA) && out_ready && !last_unit;

    gpp_walker #(
        .FB_W (FB_W),
        .AW   (AW)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .load      (walk_load),
        .rot_in    (rotated),
        .y0_in     (win_y0),
        .y1_in     (win_y1),
        .step      (walk_step),
        .addr_a    (addr_a),
        .addr_b    (addr_b),
        .last_unit (last_unit)
    );

    gpp_pair u_pair (
        .clk        (clk),
        .rst        (rst),
        .cap_first  (state_q == ST_RD_B),
        .cap_second (state_q == ST_CAP),
        .rd_data    (fb_rd_data),
        .byte_out   (packed_byte)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (walk_load) state_d = ST_CMD;
            ST_CMD:  if (out_ready && cmd_idx_q == 2'd3) state_d = ST_RD_A;
            ST_RD_A: state_d = ST_RD_B;
            ST_RD_B: state_d = ST_CAP;
            ST_CAP:  state_d = ST_DATA;
            ST_DATA: if (out_ready) state_d = last_unit ? ST_IDLE : ST_RD_A;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            win_q     <= '0;
            cmd_idx_q <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                err_q <= !bus_supported(bus_bits);
                if (bus_supported(bus_bits)) begin
                    win_q.rot  <= rotated;
                    win_q.link <= (bus_bits == 4'd9) ? LINK_9 : LINK_8;
                    win_q.x    <= win_x;
                    win_q.y0   <= win_y0;
                    cmd_idx_q  <= '0;
                end
            end else if (state_q == ST_CMD && out_ready) begin
                cmd_idx_q <= cmd_idx_q + 2'd1;
            end
        end
    end

    // rotated windows swap the coordinate roles in the address commands
    assign col_v  = win_q.rot ? win_q.y0 : win_q.x;
    assign line_v = win_q.rot ? win_q.x  : win_q.y0;

    assign fb_rd_en   = (state_q == ST_RD_A) || (state_q == ST_RD_B);
    assign fb_rd_addr = (state_q == ST_RD_B) ? addr_b : addr_a;

    assign out_valid = (state_q == ST_CMD) || (state_q == ST_DATA);
    assign out_dc    = (state_q == ST_DATA) && (win_q.link == LINK_8);
    assign out_last  = (state_q == ST_DATA) && last_unit;
    assign busy      = (state_q != ST_IDLE);
    assign err       = err_q;

    always_comb begin
        case (state_q)
            ST_CMD:  out_word = {1'b0, cmd_byte(cmd_idx_q, col_v, line_v)};
            ST_DATA: out_word = {win_q.link == LINK_9, packed_byte};
            default: out_word = '0;
        endcase
    end

    assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_word)
                                      && $stable(out_dc) && $stable(out_last));

    assert_err_is_silent_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> !out_valid && !fb_rd_en);

    assert_flag_excludes_dc_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dc) |-> !out_word[8]);

    assert_last_on_data_R11: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid && (out_dc || out_word[8]));

    assert_read_in_frame_R12: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> fb_rd_addr < FRAME_PIX);

    assert_no_read_while_offering_R12: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> !out_valid);

    assert_stream_ends_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (out_last && out_ready) |=> !busy);

endmodule

// File: tb/gray_page_packer_bench.sv
module gray_page_packer_bench;

    localparam int W  = 240;
    localparam int H  = 160;
    localparam int AW = $clog2(W * H);

    typedef struct packed {
        logic [8:0] w;
        logic       dc;
        logic       last;
        logic       is_data;
        logic       rot;
        logic       nine;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          rotated;
    logic [3:0]    bus_bits;
    logic [7:0]    win_x, win_y0, win_y1;
    logic          busy, err;
    logic          fb_rd_en;
    logic [AW-1:0] fb_rd_addr;
    logic [7:0]    fb_rd_data;
    logic          out_valid, out_ready;
    logic [8:0]    out_word;
    logic          out_dc, out_last;

    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];
    int   addr_q[$];
    bit   ready_always = 1'b1;
    logic [7:0] lfsr = 8'hA5;
    bit   stall_prev = 1'b0;
    logic [8:0] stall_word;

    always #5 clk = ~clk;

    gray_page_packer #(.FB_W(W), .FB_H(H)) u_gray_page_packer (
        .clk(clk), .rst(rst), .start(start), .rotated(rotated), .bus_bits(bus_bits),
        .win_x(win_x), .win_y0(win_y0), .win_y1(win_y1), .busy(busy), .err(err),
        .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_dc(out_dc), .out_last(out_last)
    );

    function automatic logic [7:0] pix(input int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input int tag, input int act, input int expv,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    // frame-buffer model: one cycle of read latency (R12)
    initial begin
        fb_rd_data = '0;
        forever begin
            @(posedge clk);
            if (fb_rd_en) fb_rd_data <= pix(int'(fb_rd_addr));
        end
    end

    // ready driver, changed away from both edges
    initial begin
        out_ready = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = ready_always ? 1'b1 : lfsr[0];
        end
    end

    // monitor: reads and words against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (fb_rd_en) begin
                if (addr_q.size() == 0) chk(1'b0, 12, int'(fb_rd_addr), 0, "unexpected read");
                else begin
                    int e;
                    int tg;
                    e = addr_q.pop_front();
                    tg = e >> 20;
                    chk(int'(fb_rd_addr) == (e & 20'hFFFFF), tg, int'(fb_rd_addr),
                        e & 20'hFFFFF, "read address");
                end
            end
            if (stall_prev)   // R10 hold under back-pressure
                chk(out_valid && out_word == stall_word, 10, int'(out_word),
                    int'(stall_word), "stalled word changed");
            stall_prev = out_valid && !out_ready;
            stall_word = out_word;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, 9, int'(out_word), 0, "unexpected word");
                else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    if (x.is_data) begin
                        chk(out_word[3:0] == x.w[3:0], 1, int'(out_word[3:0]),
                            int'(x.w[3:0]), "low nibble");
                        chk(out_word[7:4] == x.w[7:4], x.rot ? 4 : 2, int'(out_word[7:4]),
                            int'(x.w[7:4]), "high nibble");
                    end else begin
                        chk(out_word[7:0] == x.w[7:0], x.rot ? 6 : 5, int'(out_word[7:0]),
                            int'(x.w[7:0]), "command byte");
                    end
                    chk(out_word[8] == x.w[8], x.nine ? 7 : 8, int'(out_word[8]),
                        int'(x.w[8]), "bit 8");
                    chk(out_dc == x.dc, x.nine ? 7 : 8, int'(out_dc), int'(x.dc), "dc line");
                    chk(out_last == x.last, 11, int'(out_last), int'(x.last), "last flag");
                end
            end
        end
    end

    // driver: fills the scoreboard, then starts the window
    task automatic run_window(input bit rot, input int bits, input int x,
                              input int y0, input int y1);
        int col, ln;
        int wds[4];
        exp_t e;
        bit nine;
        nine = (bits == 9);
        col = rot ? y0 : x;    // R6 swapped roles when rotated
        ln  = rot ? x : y0;    // R5 normal roles
        wds[0] = col & 15;
        wds[1] = 16 | (col >> 4);
        wds[2] = 8'h60 | ((ln >> 1) & 15);
        wds[3] = 8'h70 | (ln >> 5);
        for (int i = 0; i < 4; i++) begin
            e = '{w: 9'(wds[i]), dc: 1'b0, last: 1'b0, is_data: 1'b0, rot: rot, nine: nine};
            exp_q.push_back(e);
        end
        if (!rot) begin
            // R2 / R3: vertical pairs from an even first line
            for (int y = (y0 & ~1); y <= y1; y += 2)
                for (int c = 0; c < W; c++) begin
                    int a;
                    logic [7:0] b;
                    a = y * W + c;
                    b = {pix(a + W)[7:4], pix(a)[7:4]};
                    addr_q.push_back((3 << 20) | a);
                    addr_q.push_back((3 << 20) | (a + W));
                    e = '{w: {nine, b}, dc: !nine, last: 1'b0, is_data: 1'b1, rot: 1'b0,
                          nine: nine};
                    exp_q.push_back(e);
                end
        end else begin
            // R4: horizontal pairs, two pixels per byte
            for (int y = y0; y <= y1; y++)
                for (int k = 0; k < W / 2; k++) begin
                    int a;
                    logic [7:0] b;
                    a = y * W + 2 * k;
                    b = {pix(a + 1)[7:4], pix(a)[7:4]};
                    addr_q.push_back((4 << 20) | a);
                    addr_q.push_back((4 << 20) | (a + 1));
                    e = '{w: {nine, b}, dc: !nine, last: 1'b0, is_data: 1'b1, rot: 1'b1,
                          nine: nine};
                    exp_q.push_back(e);
                end
        end
        e = exp_q.pop_back();
        e.last = 1'b1;          // R11 only the final data word
        exp_q.push_back(e);
        @(negedge clk);
        rotated = rot; bus_bits = 4'(bits); win_x = 8'(x); win_y0 = 8'(y0); win_y1 = 8'(y1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, 9, int'(err), 0, "err after supported start");
        do @(negedge clk); while (exp_q.size() != 0 || busy);
        chk(addr_q.size() == 0, 12, addr_q.size(), 0, "reads left over");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog expired: actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; rotated = 1'b0; bus_bits = 4'd8;
        win_x = '0; win_y0 = '0; win_y1 = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !busy && !err && !fb_rd_en, 11,
            int'({out_valid, busy, err, fb_rd_en}), 0, "reset state");

        // R2 odd start line rounds down; R7 nine-bit link; random ready
        ready_always = 1'b0;
        run_window(1'b0, 9, 5, 3, 5);
        // R4 / R6 rotated, R8 eight-bit link
        run_window(1'b1, 8, 100, 150, 151);
        // R3 bottom line pair of the frame, eight-bit link
        run_window(1'b0, 8, 239, 158, 159);

        // R9 unsupported width: silent, err raised
        @(negedge clk);
        bus_bits = 4'd7; start = 1'b1; win_y0 = 8'd10; win_y1 = 8'd12;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1 && !busy, 9, int'({err, busy}), 2, "err after bad start");
        repeat (30) begin
            @(negedge clk);
            chk(!out_valid && !fb_rd_en, 9, int'({out_valid, fb_rd_en}), 0, "silent");
        end
        chk(err == 1'b1, 9, int'(err), 1, "err held");

        // R9 clear, rotated single top line, ready always high
        ready_always = 1'b1;
        run_window(1'b1, 9, 0, 0, 0);
        // single odd line in normal orientation, random ready
        ready_always = 1'b0;
        run_window(1'b0, 9, 31, 7, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule